// File: doc/BRIEF.md
# Decimating Dual-Pipe Sample Packer

This block sits between a pair of byte-wide converter pipes and a wide acquisition memory. It accepts up to two 8-bit samples per clock and reduces them by a power-of-two ratio. Each interval of accepted samples becomes one or two result bytes. In pick mode the result is the first sample of the interval. In peak mode it is the minimum followed by the maximum. In mean mode it is the truncated average. At low rates only pipe A is used. When `cfg_dual` is set, both pipes feed the block, and pipe A's sample of a cycle counts as earlier than pipe B's.

Result bytes collect in an eight-slot group. When a group fills, it goes out as a single 64-bit write with a one-cycle strobe. The write address then advances by one. A result that arrives past the eighth slot opens the next group. A synchronous clear discards the partial group and any open interval, and restarts the address at zero.

Inside the decimator, one small state machine tracks the interval:

- `DEC_EMPTY` → `DEC_GATHER`: first sample of an interval when the ratio is above one.
- `DEC_GATHER` → `DEC_GATHER`: a middle sample.
- `DEC_GATHER` → `DEC_EMPTY`: the last sample; results are emitted.
- `DEC_EMPTY` → `DEC_EMPTY`: every sample when the ratio is one (bypass).
- Any state → `DEC_EMPTY`: reset or clear.

Top module: `sample_decim_packer`

## Requirements
- R1: After reset `wr_en`, `wr_addr` and `wr_data` are all zero, and no write happens until eight results have been collected.
- R2: With `cfg_dual`=0 only pipe A (`a_valid`/`a_data`) supplies samples and pipe B is ignored. With `cfg_dual`=1 each valid pipe supplies one sample, and A comes before B within a cycle.
- R3: The ratio is 2^`cfg_shift`, and codes above 8 act as 8. With `cfg_shift`=0 every accepted sample is one result in every mode.
- R4: In pick mode (`cfg_mode`=0, and also code 3), each interval of 2^`cfg_shift` consecutive accepted samples yields its first sample.
- R5: In peak mode (`cfg_mode`=1), each interval yields two results: the minimum first, then the maximum.
- R6: In mean mode (`cfg_mode`=2), each interval yields floor(sum / 2^`cfg_shift`).
- R7: Eight results form one write. Result k of the group (k=0 earliest) sits in `wr_data[8k+7:8k]`. `wr_en` is high for exactly one cycle, the cycle after the input cycle that supplied the eighth result. A surplus result starts the next group.
- R8: The first write after reset or clear uses address 0, and each later write uses the previous address plus one.
- R9: `clr`=1 drops the partial group, the open interval and any samples of that cycle, and restarts addressing at 0. A partial group is never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear of group, interval and address |
| cfg_mode | input | 2 | 0 pick, 1 peak, 2 mean, 3 pick |
| cfg_shift | input | 4 | log2 of decimation ratio, 0..8 |
| cfg_dual | input | 1 | 1 uses both pipes, 0 uses pipe A only |
| a_valid | input | 1 | Pipe A sample valid |
| a_data | input | 8 | Pipe A sample |
| b_valid | input | 1 | Pipe B sample valid |
| b_data | input | 8 | Pipe B sample |
| wr_en | output | 1 | One-cycle memory write strobe |
| wr_addr | output | 12 | Memory word address of this write |
| wr_data | output | 64 | Eight packed results, earliest in low byte |

## Verification
Four properties are checked on every clock:

- The interval counter never reaches the ratio.
- Each emitted peak pair is ordered minimum before maximum.
- The write strobe never lasts two cycles.
- The addresses of successive writes step by one, starting at zero after a clear.

Only the bench scenarios can show that the emitted values are correct: the first sample in pick mode, the truncated mean, the byte order across pipes, and the group that carries over a surplus byte. The same holds for showing that a cleared partial group never reaches memory and that pipe B is ignored in single mode.

// File: rtl/dm_pkg.sv
`timescale 1ns/1ps
package dm_pkg;
    typedef enum logic [1:0] {
        MODE_PICK = 2'd0,
        MODE_PEAK = 2'd1,
        MODE_MEAN = 2'd2,
        MODE_ALT  = 2'd3
    } dm_mode_e;

    typedef enum logic {
        DEC_EMPTY  = 1'b0,
        DEC_GATHER = 1'b1
    } dec_state_e;
endpackage

// File: rtl/dm_decim.sv
`timescale 1ns/1ps
module dm_decim
    import dm_pkg::*;
#(
    parameter int SW      = 8,
    parameter int MAX_LOG = 8,
    parameter int LW      = $clog2(MAX_LOG + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  dm_mode_e      mode,
    input  logic [LW-1:0] shift,
    input  logic          take_a,
    input  logic [SW-1:0] smp_a,
    input  logic          take_b,
    input  logic [SW-1:0] smp_b,
    output logic [1:0]    out_n,
    output logic [SW-1:0] out_b0,
    output logic [SW-1:0] out_b1
);
    localparam int CW   = MAX_LOG + 1;
    localparam int SUMW = SW + MAX_LOG;

    typedef struct packed {
        dec_state_e      st;
        logic [CW-1:0]   cnt;
        logic [SW-1:0]   first;
        logic [SW-1:0]   lo;
        logic [SW-1:0]   hi;
        logic [SUMW-1:0] sum;
    } acc_t;

    acc_t          acc_q, acc_a, acc_b;
    logic [1:0]    na, nb;
    logic [SW-1:0] a0, a1, b0, b1;

    // One sample through the interval state machine.
    function automatic void step(
        input  acc_t          cur,
        input  logic [SW-1:0] s,
        input  dm_mode_e      m,
        input  logic [LW-1:0] l,
        output acc_t          nx,
        output logic [1:0]    n,
        output logic [SW-1:0] e0,
        output logic [SW-1:0] e1
    );
        logic [SW-1:0]   fs, lo, hi;
        logic [SUMW-1:0] sm;
        logic [CW-1:0]   c;
        nx = cur;
        n  = 2'd0;
        e0 = '0;
        e1 = '0;
        fs = s;
        lo = s;
        hi = s;
        sm = SUMW'(s);
        c  = CW'(1);
        if (l == '0) begin
            n  = 2'd1;
            e0 = s;
        end else begin
            unique case (cur.st)
                DEC_EMPTY: begin
                    c = CW'(1);
                end
                DEC_GATHER: begin
                    fs = cur.first;
                    lo = (s < cur.lo) ? s : cur.lo;
                    hi = (s > cur.hi) ? s : cur.hi;
                    sm = cur.sum + SUMW'(s);
                    c  = cur.cnt + CW'(1);
                end
            endcase
            if (c == (CW'(1) << l)) begin
                nx = '0;
                case (m)
                    MODE_PEAK: begin
                        n  = 2'd2;
                        e0 = lo;
                        e1 = hi;
                    end
                    MODE_MEAN: begin
                        n  = 2'd1;
                        e0 = SW'(sm >> l);
                    end
                    default: begin
                        n  = 2'd1;
                        e0 = fs;
                    end
                endcase
            end else begin
                nx = '{st: DEC_GATHER, cnt: c, first: fs, lo: lo, hi: hi, sum: sm};
            end
        end
    endfunction

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_b;
        end
    end

    // Next state and outputs: pipe A first, then pipe B
    always_comb begin
        step(acc_q, smp_a, mode, shift, acc_a, na, a0, a1);
        if (!take_a) begin
            acc_a = acc_q;
            na    = 2'd0;
            a0    = '0;
            a1    = '0;
        end
        step(acc_a, smp_b, mode, shift, acc_b, nb, b0, b1);
        if (!take_b) begin
            acc_b = acc_a;
            nb    = 2'd0;
            b0    = '0;
            b1    = '0;
        end
        out_n  = na + nb;
        out_b0 = (na != 2'd0) ? a0 : b0;
        out_b1 = (na == 2'd2) ? a1 : ((na == 2'd1) ? b0 : b1);
    end

    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q.cnt < (CW'(1) << shift));

    a_r5_min_first: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PEAK && shift != '0 && out_n == 2'd2) |-> (out_b0 <= out_b1));
endmodule

// File: rtl/dm_pack.sv
`timescale 1ns/1ps
module dm_pack #(
    parameter int SW     = 8,
    parameter int GROUP  = 8,
    parameter int ADDR_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic [1:0]            in_n,
    input  logic [SW-1:0]         in_b0,
    input  logic [SW-1:0]         in_b1,
    output logic                  wr_en,
    output logic [ADDR_W-1:0]     wr_addr,
    output logic [GROUP*SW-1:0]   wr_data
);
    localparam int FW = $clog2(GROUP);
    localparam int TW = FW + 1;

    logic [GROUP-1:0][SW-1:0] slot_q, slot_d, grp;
    logic [FW-1:0]            fill_q, fill_d;
    logic [TW-1:0]            tot, pos1;
    logic [ADDR_W-1:0]        addr_q;
    logic                     full;

    always_comb begin
        grp    = slot_q;
        slot_d = '0;
        tot    = TW'(fill_q) + TW'(in_n);
        pos1   = TW'(fill_q) + TW'(1);
        if (in_n != 2'd0) begin
            grp[fill_q] = in_b0;
        end
        if (in_n == 2'd2 && pos1 < TW'(GROUP)) begin
            grp[pos1[FW-1:0]] = in_b1;
        end
        full = (tot >= TW'(GROUP));
        if (full) begin
            if (tot > TW'(GROUP)) begin
                slot_d[0] = in_b1;
            end
            fill_d = FW'(tot - TW'(GROUP));
        end else begin
            slot_d = grp;
            fill_d = FW'(tot);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            slot_q  <= '0;
            fill_q  <= '0;
            addr_q  <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            slot_q <= slot_d;
            fill_q <= fill_d;
            wr_en  <= full;
            if (full) begin
                wr_data <= grp;
                wr_addr <= addr_q;
                addr_q  <= addr_q + ADDR_W'(1);
            end
        end
    end

    // Write history for address-sequence checks
    logic              chk_seen;
    logic [ADDR_W-1:0] chk_last;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            chk_seen <= 1'b0;
            chk_last <= '0;
        end else if (wr_en) begin
            chk_seen <= 1'b1;
            chk_last <= wr_addr;
        end
    end

    a_r7_one_cycle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    a_r8_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && chk_seen) |-> (wr_addr == chk_last + ADDR_W'(1)));

    a_r9_first_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !chk_seen) |-> (wr_addr == '0));
endmodule

// File: rtl/sample_decim_packer.sv
`timescale 1ns/1ps
module sample_decim_packer
    import dm_pkg::*;
#(
    parameter int SW      = 8,
    parameter int GROUP   = 8,
    parameter int MAX_LOG = 8,
    parameter int ADDR_W  = 12,
    localparam int LW     = $clog2(MAX_LOG + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic [1:0]          cfg_mode,
    input  logic [LW-1:0]       cfg_shift,
    input  logic                cfg_dual,
    input  logic                a_valid,
    input  logic [SW-1:0]       a_data,
    input  logic                b_valid,
    input  logic [SW-1:0]       b_data,
    output logic                wr_en,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [GROUP*SW-1:0] wr_data
);
    logic [LW-1:0] eff_shift;
    logic          take_b;
    logic [1:0]    res_n;
    logic [SW-1:0] res0, res1;

    assign eff_shift = (cfg_shift > LW'(MAX_LOG)) ? LW'(MAX_LOG) : cfg_shift;
    assign take_b    = cfg_dual & b_valid;

    dm_decim #(
        .SW(SW),
        .MAX_LOG(MAX_LOG),
        .LW(LW)
    ) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .mode  (dm_mode_e'(cfg_mode)),
        .shift (eff_shift),
        .take_a(a_valid),
        .smp_a (a_data),
        .take_b(take_b),
        .smp_b (b_data),
        .out_n (res_n),
        .out_b0(res0),
        .out_b1(res1)
    );

    dm_pack #(
        .SW(SW),
        .GROUP(GROUP),
        .ADDR_W(ADDR_W)
    ) u_pack (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .in_n   (res_n),
        .in_b0  (res0),
        .in_b1  (res1),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data)
    );
endmodule

// File: tb/test_sample_decim_packer.sv
`timescale 1ns/1ps
module test_sample_decim_packer;
    localparam int NT = 12;
    localparam int T_MODE [NT] = '{0, 0, 1, 1, 1, 2, 2, 0, 2, 1, 0, 3};
    localparam int T_SH   [NT] = '{0, 2, 0, 3, 1, 1, 8, 8, 0, 8, 9, 1};
    localparam int T_DUAL [NT] = '{0, 1, 1, 0, 1, 1, 0, 1, 0, 1, 0, 1};
    localparam int T_TOT  [NT] = '{40, 160, 24, 128, 40, 64, 2048, 4096, 16, 512, 2048, 64};

    logic        clk, rst_n, clr;
    logic [1:0]  cfg_mode;
    logic [3:0]  cfg_shift;
    logic        cfg_dual;
    logic        a_valid, b_valid;
    logic [7:0]  a_data, b_data;
    logic        wr_en;
    logic [11:0] wr_addr;
    logic [63:0] wr_data;

    int n_cmp = 0;
    int n_bad = 0;
    int ncap  = 0;
    int base  = 0;
    int nsmp  = 0;
    int nexp  = 0;
    logic [7:0]  smp   [0:4095];
    logic [7:0]  expb  [0:4095];
    logic [63:0] cap_d [0:255];
    logic [11:0] cap_a [0:255];

    sample_decim_packer i_sample_decim_packer (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .cfg_mode(cfg_mode), .cfg_shift(cfg_shift), .cfg_dual(cfg_dual),
        .a_valid(a_valid), .a_data(a_data), .b_valid(b_valid), .b_data(b_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        if (rst_n && wr_en === 1'b1) begin
            if (ncap < 256) begin
                cap_d[ncap] = wr_data;
                cap_a[ncap] = wr_addr;
            end
            ncap++;
        end
    end

    task automatic check(input bit ok, input string msg, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", msg, act, exp);
        end
    endtask

    function automatic logic [7:0] gen(input int i, input int s);
        return 8'((i * 73 + s * 29 + ((i * i) >> 2)) & 255);
    endfunction

    task automatic begin_run(input int mode, input int sh, input int dual);
        @(negedge clk);
        clr = 1'b1; a_valid = 1'b1; a_data = 8'hEE; b_valid = 1'b1; b_data = 8'hEE;
        @(negedge clk);
        clr = 1'b0; a_valid = 1'b0; b_valid = 1'b0;
        cfg_mode = 2'(mode); cfg_shift = 4'(sh); cfg_dual = 1'(dual);
        base = ncap; nsmp = 0;
    endtask

    task automatic build_expected(input int mode, input int sh);
        int l;
        int r;
        l = (sh > 8) ? 8 : sh;
        r = 1 << l;
        nexp = 0;
        for (int b0 = 0; b0 + r <= nsmp; b0 += r) begin
            int lo;
            int hi;
            int sum;
            lo = 255; hi = 0; sum = 0;
            for (int j = 0; j < r; j++) begin
                int v;
                v = int'(smp[b0 + j]);
                if (v < lo) lo = v;
                if (v > hi) hi = v;
                sum += v;
            end
            if (l == 0) begin
                expb[nexp] = smp[b0]; nexp++;
            end else if (mode == 1) begin
                expb[nexp] = 8'(lo); nexp++;
                expb[nexp] = 8'(hi); nexp++;
            end else if (mode == 2) begin
                expb[nexp] = 8'(sum >> l); nexp++;
            end else begin
                expb[nexp] = smp[b0]; nexp++;
            end
        end
    endtask

    task automatic compare(input string tag);
        int nw;
        int got;
        nw  = nexp / 8;
        got = ncap - base;
        check(got == nw, {tag, " R7 write count"}, 64'(got), 64'(nw));
        for (int i = 0; i < ((got < nw) ? got : nw); i++) begin
            logic [63:0] e;
            for (int k = 0; k < 8; k++) e[8*k +: 8] = expb[8*i + k];
            check(cap_d[base + i] === e, {tag, " data (R2 R7 order/packing)"}, cap_d[base + i], e);
            check(cap_a[base + i] === 12'(i), "R8 address", 64'(cap_a[base + i]), 64'(i));
        end
    endtask

    task automatic run(input int mode, input int sh, input int dual, input int total, input int seed, input string tag);
        begin_run(mode, sh, dual);
        for (int c = 0; nsmp < total; c++) begin
            bit av;
            bit bv;
            av = ((c % 7) != 4) && (nsmp < total);
            if (dual == 0) av = ((c % 6) != 5);
            if (dual != 0 && (c % 11) == 10) av = 1'b0;
            a_valid = av;
            a_data  = gen(nsmp, seed);
            if (av) begin smp[nsmp] = a_data; nsmp++; end
            if (dual != 0) begin
                bv = ((c % 5) != 2) && ((c % 11) != 10) && (nsmp < total);
                b_valid = bv;
                b_data  = gen(nsmp, seed);
                if (bv) begin smp[nsmp] = b_data; nsmp++; end
            end else begin
                b_valid = 1'b1;
                b_data  = ~gen(c, seed + 3);
            end
            @(negedge clk);
        end
        a_valid = 1'b0; b_valid = 1'b0;
        repeat (4) @(negedge clk);
        build_expected(mode, sh);
        compare(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; clr = 1'b0; cfg_mode = 2'd0; cfg_shift = 4'd0; cfg_dual = 1'b0;
        a_valid = 1'b0; b_valid = 1'b0; a_data = 8'd0; b_data = 8'd0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(wr_en === 1'b0, "R1 wr_en after reset", 64'(wr_en), 64'd0);
        check(wr_addr === 12'd0, "R1 wr_addr after reset", 64'(wr_addr), 64'd0);
        check(wr_data === 64'd0, "R1 wr_data after reset", wr_data, 64'd0);

        // Vector table
        for (int t = 0; t < NT; t++) begin
            string tag;
            if (T_SH[t] == 0 || T_SH[t] > 8) tag = "R3";
            else if (T_MODE[t] == 1) tag = "R5";
            else if (T_MODE[t] == 2) tag = "R6";
            else tag = "R4";
            run(T_MODE[t], T_SH[t], T_DUAL[t], T_TOT[t], t + 1, tag);
        end

        // R7 strobe timing and byte order, R8 continuation
        begin_run(0, 0, 0);
        for (int k = 0; k < 7; k++) begin
            a_valid = 1'b1; a_data = 8'(8'h10 + k);
            @(posedge clk); #1;
            check(wr_en === 1'b0, "R7 no write before eighth", 64'(wr_en), 64'd0);
            @(negedge clk);
        end
        a_valid = 1'b1; a_data = 8'h17;
        @(posedge clk); #1;
        check(wr_en === 1'b1, "R7 strobe after eighth", 64'(wr_en), 64'd1);
        check(wr_data === 64'h1716151413121110, "R7 earliest in low byte", wr_data, 64'h1716151413121110);
        check(wr_addr === 12'd0, "R8 first address", 64'(wr_addr), 64'd0);
        @(negedge clk);
        a_valid = 1'b0;
        @(posedge clk); #1;
        check(wr_en === 1'b0, "R7 single-cycle strobe", 64'(wr_en), 64'd0);
        @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            a_valid = 1'b1; a_data = 8'(8'h20 + k);
            @(negedge clk);
        end
        a_valid = 1'b0;
        #1;
        check(wr_en === 1'b1 && wr_addr === 12'd1, "R8 second address", 64'(wr_addr), 64'd1);

        // R9: partial group and open interval discarded by clear
        begin_run(2, 2, 0);
        for (int k = 0; k < 14; k++) begin
            a_valid = 1'b1; a_data = 8'(8'hC0 + k);
            @(negedge clk);
        end
        a_valid = 1'b0;
        run(2, 2, 0, 32, 77, "R9");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule